// File: doc/BRIEF.md
# Linked-List Command Packet Walker

The walker follows a chain of command packets held in main memory and passes each packet's payload, one word at a time, to a peripheral. Software or a controller puts the address of the first node on `start_addr` and pulses `go`. Each node begins with a 32-bit header word. Bits 23:0 of the header point to the next node. Bits 31:24 give how many payload words follow the header at the next consecutive word addresses. Those words go out on a valid/ready port in memory order. The walk ends after the node whose next pointer has bit 23 set. `done_irq` then pulses, `busy` drops and `node_addr` reads all ones. A node limit stops a list that never ends: the walk aborts and `err` is raised.

The control is one state machine with seven states. S_IDLE waits for `go`. S_HDR_REQ issues the header read and always moves on to S_HDR_WAIT. S_HDR_WAIT waits for the read data. It goes to S_NODE_END when the count is zero and to S_PAY_REQ otherwise. S_PAY_REQ issues one payload read and moves to S_PAY_WAIT. S_PAY_WAIT waits for the data and moves to S_PAY_PUSH. S_PAY_PUSH holds the word on the output until the peripheral accepts it. After that it goes back to S_PAY_REQ, or to S_NODE_END after the last word. S_NODE_END returns to S_IDLE on an end pointer or when the limit is reached. Otherwise it goes to S_HDR_REQ for the next node.

The memory port accepts a one-cycle `mem_req` at once. It answers with one `mem_rvalid` cycle some cycles later. The walker never has more than one read in flight.

Top module: `llw_walker`

## Requirements
- R1: A `go` pulse seen while idle starts a walk. In the next cycle `busy` is high and a header read is requested at `start_addr` with bits 1:0 cleared.
- R2: In a header word, bits 31:24 are the payload count (0 to 255) and bits 23:0 are the next pointer. The payload words are read from the header address plus 4, plus 8, and so on, and are sent on `out_data` in that order, one word per accepted transfer.
- R3: `mem_req` lasts one cycle per read. No new read is requested until the previous read has returned on `mem_rvalid`.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R5: A node whose count is zero makes no payload read and no output transfer. The next header is fetched right after it.
- R6: The walk ends after the node whose next pointer has bit 23 set, whatever the other pointer bits are. No further header is read.
- R7: Every memory read address has bits 1:0 equal to zero. The next header is read at the next pointer with bits 1:0 cleared.
- R8: When a walk ends normally, `done_irq` is high for exactly one cycle. In that cycle `busy` is low and `node_addr` reads 0xFFFFFF.
- R9: Once MAX_NODES headers have been processed and the last of them does not end the list, the walk aborts without a further read. `err` goes high, `busy` drops, `done_irq` stays low and `node_addr` holds the aligned address of the node that was not fetched. `err` clears when the next walk is accepted.
- R10: After reset, `busy`, `mem_req`, `out_valid`, `done_irq` and `err` are low.
- R11: A `go` pulse while `busy` is high is ignored, and the walk in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start strobe, accepted only while idle |
| start_addr | input | 24 | Byte address of the first node |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 24 | Word-aligned read address |
| mem_rvalid | input | 1 | Read data valid, one cycle per request |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Payload word available |
| out_data | output | 32 | Payload word |
| out_ready | input | 1 | Peripheral accepts the word |
| busy | output | 1 | Walk in progress |
| done_irq | output | 1 | One-cycle pulse when a list ends normally |
| err | output | 1 | Walk aborted at the node limit |
| node_addr | output | 24 | Current node address; all ones after a normal end |

## Verification
Several properties hold on every cycle and are checked by assertions. These cover the single outstanding read, aligned read addresses and the output held under backpressure. They also cover the relation of `done_irq` to `busy` and the all-ones address, the bound on the node counter, and the first header read after an accepted `go`. Other behaviour can only be shown by the bench's scenarios. These are the order and content of the payload stream, skipping an empty node, ending on a pointer that is not all ones, the 255-word boundary, the abort of a circular list and the clearing of `err`, and a `go` ignored during a walk. In each scenario a behavioural reference walks the same memory image, and the bench compares every read address and every transfer against it.

// File: rtl/llw_pkg.sv
package llw_pkg;

    localparam int ADDR_W     = 24;
    localparam int CNT_W      = 8;
    localparam int WORD_W     = 32;
    localparam int END_BIT    = 23;
    localparam int WORD_BYTES = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR_REQ,
        S_HDR_WAIT,
        S_PAY_REQ,
        S_PAY_WAIT,
        S_PAY_PUSH,
        S_NODE_END
    } walk_state_t;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [ADDR_W-1:0] link;
    } node_hdr_t;

    function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
        return a & ~ADDR_W'(WORD_BYTES - 1);
    endfunction

endpackage

// File: rtl/llw_node_guard.sv
module llw_node_guard #(
    parameter int MAX_NODES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic incr,
    output logic limit_hit
);
    localparam int CW = $clog2(MAX_NODES + 1);

    logic [CW-1:0] seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= '0;
        end else if (clear) begin
            seen <= '0;
        end else if (incr && !limit_hit) begin
            seen <= seen + CW'(1);
        end
    end

    assign limit_hit = (seen >= CW'(MAX_NODES));

    // R9: the node counter never runs past the configured limit
    a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        seen <= CW'(MAX_NODES));

endmodule

// File: rtl/llw_out_stage.sv
module llw_out_stage #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          ready,
    output logic          valid,
    output logic [DW-1:0] data,
    output logic          fire
);
    assign fire = valid && ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            if (load) begin
                valid <= 1'b1;
                data  <= din;
            end else if (fire) begin
                valid <= 1'b0;
            end
        end
    end

    // R4: a stalled word stays presented and unchanged
    a_r4_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready |=> valid && $stable(data));

    // R4: a new word is never loaded over one not yet accepted
    a_r4_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !valid);

endmodule

// File: rtl/llw_addr_unit.sv
module llw_addr_unit
    import llw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              ld_hdr,
    input  node_hdr_t         hdr,
    input  logic              step,
    input  logic              ld_next,
    output logic [ADDR_W-1:0] node_addr,
    output logic [ADDR_W-1:0] pay_addr,
    output logic              link_ends,
    output logic              last_word
);
    localparam logic [ADDR_W-1:0] STRIDE   = ADDR_W'(WORD_BYTES);
    localparam logic [ADDR_W-1:0] ALL_ONES = '1;

    logic [ADDR_W-1:0] link_q;
    logic [CNT_W-1:0]  remain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            node_addr <= '0;
            pay_addr  <= '0;
            link_q    <= '0;
            remain_q  <= '0;
        end else begin
            if (ld_start) begin
                node_addr <= word_align(start_addr);
            end else if (ld_next) begin
                node_addr <= link_ends ? ALL_ONES : word_align(link_q);
            end
            if (ld_hdr) begin
                link_q   <= hdr.link;
                remain_q <= hdr.count;
                pay_addr <= node_addr + STRIDE;
            end else if (step) begin
                remain_q <= remain_q - CNT_W'(1);
                pay_addr <= pay_addr + STRIDE;
            end
        end
    end

    assign link_ends = link_q[END_BIT];
    assign last_word = (remain_q == CNT_W'(1));

    // R7: header addresses taken from a pointer are always word aligned
    a_r7_node_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ld_next && !link_ends |=> node_addr[1:0] == 2'b00);

endmodule

// File: rtl/llw_walker.sv
module llw_walker
    import llw_pkg::*;
#(
    parameter int MAX_NODES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    input  logic              out_ready,
    output logic              busy,
    output logic              done_irq,
    output logic              err,
    output logic [ADDR_W-1:0] node_addr
);
    walk_state_t state, state_nx;

    node_hdr_t         hdr_in;
    logic              ld_start, ld_hdr, load_out, step, ld_next;
    logic              fire, limit_hit, link_ends, last_word, hdr_phase;
    logic [ADDR_W-1:0] pay_addr;

    assign hdr_in = node_hdr_t'(mem_rdata);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (go) state_nx = S_HDR_REQ;
            S_HDR_REQ:  state_nx = S_HDR_WAIT;
            S_HDR_WAIT: if (mem_rvalid)
                            state_nx = (hdr_in.count == '0) ? S_NODE_END : S_PAY_REQ;
            S_PAY_REQ:  state_nx = S_PAY_WAIT;
            S_PAY_WAIT: if (mem_rvalid) state_nx = S_PAY_PUSH;
            S_PAY_PUSH: if (fire) state_nx = last_word ? S_NODE_END : S_PAY_REQ;
            S_NODE_END: state_nx = (link_ends || limit_hit) ? S_IDLE : S_HDR_REQ;
            default:    state_nx = S_IDLE;
        endcase
    end

    // outputs and datapath strobes
    always_comb begin
        ld_start  = (state == S_IDLE) && go;
        ld_hdr    = (state == S_HDR_WAIT) && mem_rvalid;
        load_out  = (state == S_PAY_WAIT) && mem_rvalid;
        step      = (state == S_PAY_PUSH) && fire;
        ld_next   = (state == S_NODE_END);
        hdr_phase = (state == S_HDR_REQ);
        mem_req   = (state == S_HDR_REQ) || (state == S_PAY_REQ);
        busy      = (state != S_IDLE);
    end

    assign mem_addr = hdr_phase ? node_addr : pay_addr;

    // completion and fault flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_irq <= 1'b0;
            err      <= 1'b0;
        end else begin
            done_irq <= ld_next && link_ends;
            if (ld_start)
                err <= 1'b0;
            else if (ld_next && !link_ends && limit_hit)
                err <= 1'b1;
        end
    end

    llw_addr_unit u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_start   (ld_start),
        .start_addr (start_addr),
        .ld_hdr     (ld_hdr),
        .hdr        (hdr_in),
        .step       (step),
        .ld_next    (ld_next),
        .node_addr  (node_addr),
        .pay_addr   (pay_addr),
        .link_ends  (link_ends),
        .last_word  (last_word)
    );

    llw_node_guard #(.MAX_NODES(MAX_NODES)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (ld_start),
        .incr      (ld_hdr),
        .limit_hit (limit_hit)
    );

    llw_out_stage #(.DW(WORD_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_out),
        .din   (mem_rdata),
        .ready (out_ready),
        .valid (out_valid),
        .data  (out_data),
        .fire  (fire)
    );

    // read-in-flight tracker for the request discipline check
    logic rd_pending;
    always_ff @(posedge clk) begin
        if (!rst_n)          rd_pending <= 1'b0;
        else if (mem_req)    rd_pending <= 1'b1;
        else if (mem_rvalid) rd_pending <= 1'b0;
    end

    // R3: no request while a read is still in flight
    a_r3_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !rd_pending);

    // R3: a request lasts exactly one cycle
    a_r3_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R7: every read address is word aligned
    a_r7_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);

    // R1: an accepted go leads straight to the first header read
    a_r1_start_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        go && !busy |=> busy && mem_req && mem_addr == word_align($past(start_addr)));

    // R8: the end pulse comes with the walker idle and the address all ones
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> !busy && node_addr == '1);

    // R8: the end pulse lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    // R9: an abort leaves the walker idle and raises no end pulse
    a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy && !done_irq);

    // R10: a word is only presented during a walk
    a_r10_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

endmodule

// File: tb/sim_llw_walker.sv
module sim_llw_walker;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic [23:0] start_addr = '0;
    logic        mem_req;
    logic [23:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_ready = 1'b1;
    logic        busy, done_irq, err;
    logic [23:0] node_addr;

    llw_walker #(.MAX_NODES(LIMIT)) u0 (
        .clk(clk), .rst_n(rst_n), .go(go), .start_addr(start_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .busy(busy), .done_irq(done_irq), .err(err),
        .node_addr(node_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    logic [31:0] mem [0:511];
    logic [23:0] q_addr [$];
    logic [31:0] q_data [$];
    int          lat = 1;
    bit          rdy_rand = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int          resp_cnt = 0;
    logic [23:0] resp_addr = '0;
    int          done_seen = 0;
    bit          exp_err, exp_done;
    logic [23:0] exp_final;

    function automatic int widx(input logic [23:0] a);
        return int'(a[10:2]);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // behavioural walk of the memory image
    task automatic model_walk(input logic [23:0] start);
        logic [23:0] a;
        logic [31:0] h;
        int n;
        a = start & 24'hFFFFFC;
        n = 0;
        q_addr.delete();
        q_data.delete();
        exp_err = 1'b0;
        exp_done = 1'b0;
        forever begin
            q_addr.push_back(a);
            h = mem[widx(a)];
            n++;
            for (int i = 1; i <= int'(h[31:24]); i++) begin
                q_addr.push_back(a + 24'(4*i));
                q_data.push_back(mem[widx(a + 24'(4*i))]);
            end
            if (h[23]) begin
                exp_done = 1'b1;
                exp_final = 24'hFFFFFF;
                break;
            end
            if (n == LIMIT) begin
                exp_err = 1'b1;
                exp_final = h[23:0] & 24'hFFFFFC;
                break;
            end
            a = h[23:0] & 24'hFFFFFC;
        end
    endtask

    // memory responder and per-clock comparison
    always @(negedge clk) begin
        logic [31:0] e;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = rdy_rand ? lfsr[0] : 1'b1;
        if (mem_rvalid) mem_rvalid = 1'b0;
        if (resp_cnt > 0) begin
            resp_cnt--;
            if (resp_cnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata = mem[widx(resp_addr)];
            end
        end
        if (rst_n && mem_req) begin
            if (q_addr.size() == 0) begin
                check(1'b0, "R6", "request past end of walk", {8'h0, mem_addr}, 32'h0);
            end else begin
                e = {8'h0, q_addr.pop_front()};
                check({8'h0, mem_addr} == e, "R7", "read address", {8'h0, mem_addr}, e);
            end
            resp_addr = mem_addr;
            resp_cnt = lat;
        end
        if (rst_n && out_valid && out_ready) begin
            if (q_data.size() == 0) begin
                check(1'b0, "R5", "unexpected transfer", out_data, 32'h0);
            end else begin
                e = q_data.pop_front();
                check(out_data == e, "R2", "payload word", out_data, e);
            end
        end
        if (rst_n && done_irq) done_seen++;
    end

    task automatic run_walk(input logic [23:0] start, input int l, input bit rr,
                            input bit interfere, input string tags);
        model_walk(start);
        lat = l;
        rdy_rand = rr;
        done_seen = 0;
        @(negedge clk);
        go = 1'b1;
        start_addr = start;
        @(negedge clk);
        go = 1'b0;
        check(busy == 1'b1, "R1", "busy after go", {31'h0, busy}, 32'h1);
        if (interfere) begin
            repeat (5) @(negedge clk);
            check(busy == 1'b1, "R11", "still busy before second go", {31'h0, busy}, 32'h1);
            go = 1'b1;
            start_addr = 24'h000400;
            @(negedge clk);
            go = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        check(q_addr.size() == 0, tags, "reads left unmade", q_addr.size(), 0);
        check(q_data.size() == 0, tags, "words left unsent", q_data.size(), 0);
        check(done_seen == int'(exp_done), tags, "done pulses", done_seen, int'(exp_done));
        check(err == exp_err, tags, "err flag", {31'h0, err}, {31'h0, exp_err});
        check(node_addr == exp_final, tags, "final node address",
              {8'h0, node_addr}, {8'h0, exp_final});
        check(busy == 1'b0, tags, "busy released", {31'h0, busy}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
        mem[widx(24'h000100)] = {8'd3,   24'h000141};
        mem[widx(24'h000140)] = {8'd0,   24'h000203};
        mem[widx(24'h000200)] = {8'd2,   24'h800123};
        mem[widx(24'h000300)] = {8'd1,   24'h000302};
        mem[widx(24'h000400)] = {8'd255, 24'hFFFFFF};

        repeat (3) @(negedge clk);
        // R10: reset state
        check(busy == 1'b0,      "R10", "busy in reset",     {31'h0, busy},      32'h0);
        check(mem_req == 1'b0,   "R10", "mem_req in reset",  {31'h0, mem_req},   32'h0);
        check(out_valid == 1'b0, "R10", "out_valid in reset", {31'h0, out_valid}, 32'h0);
        check(done_irq == 1'b0,  "R10", "done in reset",     {31'h0, done_irq},  32'h0);
        check(err == 1'b0,       "R10", "err in reset",      {31'h0, err},       32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R5 R6 R7 R8: unaligned start, empty node, end pointer 0x800123
        run_walk(24'h000102, 1, 1'b0, 1'b0, "R1 R5 R6 R8");
        // R4 R11: same list with slow memory, stalling peripheral, stray go
        run_walk(24'h000102, 3, 1'b1, 1'b1, "R4 R11");
        // R2: full 255-word payload in one node
        run_walk(24'h000400, 2, 1'b0, 1'b0, "R2 R8");
        // R9: circular list aborts at the node limit
        run_walk(24'h000300, 1, 1'b1, 1'b0, "R9");
        // R9: err clears on the next accepted walk
        run_walk(24'h000100, 2, 1'b1, 1'b0, "R9 R6");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule